// File: doc/BRIEF.md
# USB Receive Endpoint Control

This block holds the control and status state of one device-mode USB receive endpoint. A packet-receive front end strobes it when a good data packet arrives. The block answers at once with the handshake to return, and it raises a packet-ready flag. The CPU or a DMA engine then unloads the packet from the receive FIFO, and the block counts the bytes as they leave. With auto-clear enabled, the flag drops once a whole maximum-size packet has gone. Otherwise software drops it with an explicit clear.

A configuration byte controls the endpoint. Its fields select auto-clear, bulk/interrupt or isochronous transfers, DMA request enable, NYET suppression (this field reports a PID error in isochronous mode), and the DMA interrupt mode. The DMA request follows the flag while DMA is enabled. The interrupt fires either once per DMA-unloaded packet or once when the DMA engine reports that the whole transfer is complete. The block keeps whole-transfer mode in force until DMA enable has actually dropped.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0x00, and the ready flag, unload count, DMA request and interrupt are all 0.
- R2: A configuration write stores bits 7..3, which read back as follows: bit 7 auto-clear, bit 6 transfer type (0 = isochronous, 1 = bulk/interrupt), bit 5 DMA enable, bit 4 NYET disable, bit 3 DMA mode. Bits 2..0 always read 0 and ignore writes.
- R3: A receive strobe while the flag is clear sets the flag at the next edge. A strobe while the flag is set leaves the flag and the count unchanged and returns NAK on a bulk endpoint.
- R4: While the flag is set, a CPU read strobe adds 1 to the unload count and a DMA read strobe adds 4. Read strobes while the flag is clear are ignored, and the count stays 0.
- R5: With auto-clear set, an unload that brings the count to or past the maximum packet size clears the flag and the count at the next edge.
- R6: Without such an unload (a short packet, or auto-clear off), the flag stays set until the software clear strobe. That strobe clears the flag and the count at the next edge.
- R7: The handshake code is valid in the same cycle as the receive strobe and uses 0 = ACK, 1 = NAK, 2 = NYET, 3 = none. On a bulk endpoint with the flag clear, the code is NYET when the FIFO-full input is high and NYET disable is 0. In every other case it is ACK.
- R8: On an isochronous endpoint the handshake code is always 3 (none). There, config bit 4 reads the PID-error input latched from the last accepted packet.
- R9: The DMA request is high exactly while the flag is set and DMA enable is 1.
- R10: With DMA enabled and mode 0 in effect, every auto-clear gives a one-cycle interrupt pulse in the same cycle that the flag reads 0.
- R11: With DMA enabled and mode 1 in effect, auto-clears raise no interrupt. The first cycle of a transfer-complete input gives a one-cycle pulse after the next edge, unless a pulse is already high.
- R12: Once DMA enable and mode 1 are both set, mode 1 stays in effect after the mode bit is written to 0 until DMA enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration/status readback |
| max_pkt | input | MAXW | Maximum packet size in bytes |
| pkt_rcv | input | 1 | Good packet received strobe |
| pkt_pid_err | input | 1 | PID error seen in the received packet |
| fifo_full | input | 1 | This packet fills the receive FIFO |
| hs_code | output | 2 | Handshake to return for the strobe |
| rdy_clr | input | 1 | Software clear of the ready flag |
| cpu_rd | input | 1 | CPU one-byte FIFO read strobe |
| dma_rd | input | 1 | DMA four-byte FIFO read strobe |
| dma_done | input | 1 | DMA whole-transfer complete |
| rdy | output | 1 | Packet-ready flag |
| unload_cnt | output | MAXW+1 | Bytes unloaded from the current packet |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | DMA interrupt pulse |

## Verification
The handshake code is combinational, so it is due in the same cycle as the receive strobe. Every other result is due after the first rising edge that follows the stimulus. This applies to the flag, the count, the readback, the DMA request and the interrupt pulse, which are each one register deep. The bench drives inputs on the falling edge and checks the handshake 1 ns later, before the rising edge. It checks the registered results 1 ns after that rising edge, against a model stepped once per cycle. No result is ever read two edges late.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;

  typedef enum logic [1:0] {
    HS_ACK  = 2'd0,
    HS_NAK  = 2'd1,
    HS_NYET = 2'd2,
    HS_NONE = 2'd3
  } hs_e;

  // field order matches config byte bits 7..3
  typedef struct packed {
    logic autoclr;
    logic bulk;
    logic dma_en;
    logic nyet_dis;
    logic dma_mode;
  } cfg_t;

  localparam int CFG_LSB = 3;

  function automatic cfg_t cfg_from_byte(input logic [7:0] b);
    return cfg_t'(b[7:CFG_LSB]);
  endfunction

  function automatic logic [7:0] cfg_to_byte(input cfg_t c, input logic pid);
    logic [7:0] b;
    b = {c, 3'b000};
    if (!c.bulk) b[4] = pid;
    return b;
  endfunction

  function automatic logic [2:0] unload_step(input logic cpu, input logic dma);
    return {dma, 2'b00} + {2'b00, cpu};
  endfunction

endpackage

// File: rtl/rxep_cfg.sv
module rxep_cfg
  import usb_rxep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       pkt_acc,
  input  logic       pid_err,
  output cfg_t       cfg,
  output logic       mode_eff,
  output logic [7:0] rdata
);
  cfg_t cfg_q;
  logic lat_q;
  logic pid_q;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lat_q <= 1'b0;
      pid_q <= 1'b0;
    end else begin
      if (wr) cfg_q <= cfg_from_byte(wdata);
      lat_q <= cfg_q.dma_en & (lat_q | cfg_q.dma_mode);
      if (pkt_acc) pid_q <= pid_err & ~cfg_q.bulk;
    end
  end

  assign cfg      = cfg_q;
  assign mode_eff = cfg_q.dma_mode | lat_q;
  assign rdata    = cfg_to_byte(cfg_q, pid_q);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.dma_en && $past(cfg_q.dma_en) && $past(mode_eff)) |-> mode_eff); // R12

endmodule

// File: rtl/rxep_unload.sv
module rxep_unload
  import usb_rxep_pkg::*;
#(
  parameter  int MAXW = 11,
  localparam int CNTW = MAXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            autoclr,
  input  logic [MAXW-1:0] max_pkt,
  input  logic            pkt_rcv,
  input  logic            rdy_clr,
  input  logic            cpu_rd,
  input  logic            dma_rd,
  output logic            rdy,
  output logic [CNTW-1:0] cnt,
  output logic            pkt_acc,
  output logic            auto_hit
);
  logic            rdy_q;
  logic [CNTW-1:0] cnt_q;
  logic [2:0]      step;
  logic [CNTW-1:0] sum;

  function automatic logic [CNTW-1:0] sat_add(input logic [CNTW-1:0] a,
                                              input logic [2:0] s);
    logic [CNTW:0] w;
    w = {1'b0, a} + {{(CNTW-2){1'b0}}, s};
    return w[CNTW] ? {CNTW{1'b1}} : w[CNTW-1:0];
  endfunction

  assign step     = unload_step(cpu_rd, dma_rd);
  assign sum      = sat_add(cnt_q, step);
  assign pkt_acc  = pkt_rcv & ~rdy_q;
  assign auto_hit = rdy_q & autoclr & (step != 3'd0) & (sum >= {1'b0, max_pkt});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (!rdy_q) begin
      rdy_q <= pkt_rcv;
      cnt_q <= '0;
    end else if (rdy_clr || auto_hit) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= sum;
    end
  end

  assign rdy = rdy_q;
  assign cnt = cnt_q;

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_q |-> (cnt_q == '0)); // R4
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> (!rdy_q && cnt_q == '0)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rcv && rdy_q && !rdy_clr && !auto_hit) |=> rdy_q); // R3

endmodule

// File: rtl/rxep_hs.sv
module rxep_hs
  import usb_rxep_pkg::*;
(
  input  logic pkt_rcv,
  input  logic rdy,
  input  logic bulk,
  input  logic nyet_dis,
  input  logic fifo_full,
  output hs_e  hs
);
  always_comb begin
    if (!pkt_rcv || !bulk)         hs = HS_NONE;
    else if (rdy)                  hs = HS_NAK;
    else if (fifo_full && !nyet_dis) hs = HS_NYET;
    else                           hs = HS_ACK;
  end
endmodule

// File: rtl/rxep_dma_irq.sv
module rxep_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  input  logic dma_en,
  input  logic mode_eff,
  input  logic auto_hit,
  input  logic dma_done,
  output logic dma_req,
  output logic irq
);
  logic done_q;
  logic irq_q;
  logic ev_pkt;
  logic ev_xfer;

  assign ev_pkt  = auto_hit & dma_en & ~mode_eff;
  assign ev_xfer = dma_done & ~done_q & dma_en & mode_eff & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= dma_done;
      irq_q  <= ev_pkt | ev_xfer;
    end
  end

  assign dma_req = rdy & dma_en;
  assign irq     = irq_q;

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> !dma_req); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R10
  AST_MODE1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_hit && mode_eff && !dma_done) |=> !irq_q); // R11

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rxep_pkg::*;
#(
  parameter  int MAXW = 11,
  localparam int CNTW = MAXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic [MAXW-1:0] max_pkt,
  input  logic            pkt_rcv,
  input  logic            pkt_pid_err,
  input  logic            fifo_full,
  output logic [1:0]      hs_code,
  input  logic            rdy_clr,
  input  logic            cpu_rd,
  input  logic            dma_rd,
  input  logic            dma_done,
  output logic            rdy,
  output logic [CNTW-1:0] unload_cnt,
  output logic            dma_req,
  output logic            irq
);
  cfg_t cfg;
  logic mode_eff;
  logic pkt_acc;
  logic auto_hit;
  hs_e  hs;

  rxep_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .pkt_acc  (pkt_acc),
    .pid_err  (pkt_pid_err),
    .cfg      (cfg),
    .mode_eff (mode_eff),
    .rdata    (cfg_rdata)
  );

  rxep_unload #(.MAXW(MAXW)) u_unload (
    .clk      (clk),
    .rst_n    (rst_n),
    .autoclr  (cfg.autoclr),
    .max_pkt  (max_pkt),
    .pkt_rcv  (pkt_rcv),
    .rdy_clr  (rdy_clr),
    .cpu_rd   (cpu_rd),
    .dma_rd   (dma_rd),
    .rdy      (rdy),
    .cnt      (unload_cnt),
    .pkt_acc  (pkt_acc),
    .auto_hit (auto_hit)
  );

  rxep_hs u_hs (
    .pkt_rcv   (pkt_rcv),
    .rdy       (rdy),
    .bulk      (cfg.bulk),
    .nyet_dis  (cfg.nyet_dis),
    .fifo_full (fifo_full),
    .hs        (hs)
  );

  assign hs_code = hs;

  rxep_dma_irq u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (rdy),
    .dma_en   (cfg.dma_en),
    .mode_eff (mode_eff),
    .auto_hit (auto_hit),
    .dma_done (dma_done),
    .dma_req  (dma_req),
    .irq      (irq)
  );

endmodule

// File: tb/sim_usb_rx_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_rx_ep_ctrl;
  localparam int MAXW = 11;
  localparam int CW   = MAXW + 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, pkt_rcv, pkt_pid_err, fifo_full, rdy_clr, cpu_rd, dma_rd, dma_done;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [MAXW-1:0] max_pkt;
  logic [1:0] hs_code;
  logic rdy, dma_req, irq;
  logic [CW-1:0] unload_cnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] m_cfg;
  logic m_rdy, m_lat, m_pid, m_dprev, m_irq;
  int   m_cnt;

  always #2.5 clk = ~clk;

  usb_rx_ep_ctrl #(.MAXW(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .max_pkt(max_pkt), .pkt_rcv(pkt_rcv),
    .pkt_pid_err(pkt_pid_err), .fifo_full(fifo_full), .hs_code(hs_code),
    .rdy_clr(rdy_clr), .cpu_rd(cpu_rd), .dma_rd(dma_rd), .dma_done(dma_done),
    .rdy(rdy), .unload_cnt(unload_cnt), .dma_req(dma_req), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // handshake from R3/R7/R8: 0 ACK, 1 NAK, 2 NYET, 3 none
  function automatic int exp_hs(input logic pkt, input logic full);
    if (!pkt || !m_cfg[6]) return 3;
    if (m_rdy) return 1;
    if (full && !m_cfg[4]) return 2;
    return 0;
  endfunction

  function automatic int exp_rdata();
    logic [7:0] b;
    b = {m_cfg[7:3], 3'b000};
    if (!m_cfg[6]) b[4] = m_pid;
    return int'(b);
  endfunction

  task automatic step(input string tag, input logic i_pkt, input logic i_full,
                      input logic i_pid, input logic i_cpu, input logic i_dma,
                      input logic i_clr, input logic i_done, input logic i_wr,
                      input logic [7:0] i_wd);
    int   s, inc;
    logic hit, meff, n_rdy, n_irq, n_lat, n_pid;
    int   n_cnt;
    @(negedge clk);
    pkt_rcv = i_pkt; fifo_full = i_full; pkt_pid_err = i_pid;
    cpu_rd = i_cpu; dma_rd = i_dma; rdy_clr = i_clr; dma_done = i_done;
    cfg_wr = i_wr; cfg_wdata = i_wd;
    #1;
    chk(tag, "hs_code", int'(hs_code), exp_hs(i_pkt, i_full));
    inc  = (i_cpu ? 1 : 0) + (i_dma ? 4 : 0);
    meff = m_cfg[3] | m_lat;
    hit  = 1'b0;
    n_pid = m_pid;
    if (!m_rdy) begin
      n_rdy = i_pkt; n_cnt = 0;
      if (i_pkt) n_pid = i_pid & ~m_cfg[6];
    end else begin
      s = m_cnt + inc;
      if (s > CMAX) s = CMAX;
      hit = m_cfg[7] && inc != 0 && s >= int'(max_pkt);
      if (i_clr || hit) begin n_rdy = 0; n_cnt = 0; end
      else begin n_rdy = 1; n_cnt = s; end
    end
    n_irq = (hit && m_cfg[5] && !meff) ||
            (i_done && !m_dprev && m_cfg[5] && meff && !m_irq);
    n_lat = m_cfg[5] & meff;
    m_rdy = n_rdy; m_cnt = n_cnt; m_irq = n_irq; m_lat = n_lat; m_pid = n_pid;
    m_dprev = i_done;
    if (i_wr) m_cfg = {i_wd[7:3], 3'b000};
    @(posedge clk);
    #1;
    chk(tag, "rdy", int'(rdy), int'(m_rdy));
    chk(tag, "unload_cnt", int'(unload_cnt), m_cnt);
    chk(tag, "dma_req", int'(dma_req), int'(m_rdy & m_cfg[5]));
    chk(tag, "irq", int'(irq), int'(m_irq));
    chk(tag, "cfg_rdata", int'(cfg_rdata), exp_rdata());
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
  endtask
  task automatic wcfg(input string tag, input logic [7:0] v);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, v);
  endtask
  task automatic rx(input string tag, input logic full, input logic pid);
    step(tag, 1, full, pid, 0, 0, 0, 0, 0, 8'h00);
  endtask
  task automatic rdc(input string tag);
    step(tag, 0, 0, 0, 1, 0, 0, 0, 0, 8'h00);
  endtask
  task automatic rdd(input string tag);
    step(tag, 0, 0, 0, 0, 1, 0, 0, 0, 8'h00);
  endtask
  task automatic clr(input string tag);
    step(tag, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00);
  endtask
  task automatic done(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 0, 8'h00);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_n = 0; cfg_wr = 0; cfg_wdata = 0; pkt_rcv = 0; pkt_pid_err = 0;
    fifo_full = 0; rdy_clr = 0; cpu_rd = 0; dma_rd = 0; dma_done = 0;
    max_pkt = 11'd8;
    m_cfg = 0; m_rdy = 0; m_cnt = 0; m_lat = 0; m_pid = 0; m_dprev = 0; m_irq = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "cfg_rdata", int'(cfg_rdata), 0);
    chk("R1", "rdy", int'(rdy), 0);
    chk("R1", "unload_cnt", int'(unload_cnt), 0);
    chk("R1", "dma_req", int'(dma_req), 0);
    chk("R1", "irq", int'(irq), 0);

    // R2 field layout and reserved bits
    wcfg("R2", 8'hFF);
    chk("R2", "readback", int'(cfg_rdata), 8'hF8);
    wcfg("R2", 8'h47);
    chk("R2", "readback", int'(cfg_rdata), 8'h40);

    // R3 busy packet gets NAK, state kept; R4 counting
    rx("R3", 0, 0);
    rdc("R4"); rdc("R4"); rdd("R4");
    chk("R4", "count 1+1+4", int'(unload_cnt), 6);
    rx("R3", 0, 0);
    chk("R3", "rdy kept", int'(rdy), 1);
    chk("R3", "count kept", int'(unload_cnt), 6);
    clr("R6");
    rdc("R4"); rdd("R4");
    chk("R4", "ignored when idle", int'(unload_cnt), 0);

    // R5 auto-clear with DMA words
    wcfg("R5", 8'hC0);
    max_pkt = 11'd8;
    rx("R5", 0, 0); rdd("R5");
    chk("R5", "half unloaded", int'(rdy), 1);
    rdd("R5");
    chk("R5", "auto cleared", int'(rdy), 0);

    // R6 short packet stays until software clear
    rx("R6", 0, 0); rdc("R6"); rdc("R6"); rdc("R6");
    idle("R6"); idle("R6");
    chk("R6", "short stays", int'(rdy), 1);
    clr("R6");
    chk("R6", "sw clear", int'(rdy), 0);

    // R7 NYET selection
    wcfg("R7", 8'h40);
    rx("R7", 1, 0);   // expects NYET
    clr("R7");
    wcfg("R7", 8'h50);
    rx("R7", 1, 0);   // expects ACK
    clr("R7");

    // R8 isochronous: no handshake, PID error readback
    wcfg("R8", 8'h00);
    rx("R8", 1, 1);
    chk("R8", "pid bit", int'(cfg_rdata[4]), 1);
    rx("R8", 0, 0);
    clr("R8");
    rx("R8", 0, 0);
    chk("R8", "pid bit clear", int'(cfg_rdata[4]), 0);
    clr("R8");

    // R9/R10 DMA per-packet interrupt
    wcfg("R10", 8'hE0);
    max_pkt = 11'd4;
    rx("R9", 0, 0);
    chk("R9", "request up", int'(dma_req), 1);
    rdd("R10");
    chk("R10", "pulse", int'(irq), 1);
    idle("R10");
    chk("R10", "pulse ends", int'(irq), 0);

    // R11 whole-transfer interrupt
    wcfg("R11", 8'hE8);
    rx("R11", 0, 0); rdd("R11");
    chk("R11", "no per-packet", int'(irq), 0);
    done("R11");
    chk("R11", "done pulse", int'(irq), 1);
    done("R11");
    chk("R11", "held done no repeat", int'(irq), 0);
    idle("R11");

    // R12 mode retained while enable stays
    wcfg("R12", 8'hE0);
    rx("R12", 0, 0); rdd("R12");
    chk("R12", "mode1 kept", int'(irq), 0);
    done("R12");
    chk("R12", "done pulse", int'(irq), 1);
    wcfg("R12", 8'hC0);
    idle("R12");
    wcfg("R12", 8'hE0);
    rx("R12", 0, 0); rdd("R12");
    chk("R12", "mode0 after drop", int'(irq), 1);

    // random phase
    for (int seg = 0; seg < 60; seg++) begin
      idle("R5");
      if (!m_rdy) max_pkt = MAXW'(1 + $urandom % 16);
      for (int i = 0; i < 50; i++) begin
        int r;
        r = $urandom % 100;
        if (r < 5) wcfg("R2", 8'($urandom));
        else step("R4", ($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
                  ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 40) == 0,
                  ($urandom % 20) == 0, 0, 8'h00);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule